// File: doc/BRIEF.md
# Serial-Addressed Successive-Approximation Converter Controller

This block is the digital controller of an 8-bit successive-approximation converter that a host drives over a serial link. The host lowers the frame select, clocks in a start bit and a 4-bit input-selection word, and then reads the result back on the serial output. Each bit of the result appears as soon as the comparison that produces it has been made, most significant bit first. After that the same result is sent again least significant bit first, and a hold input can pause this second stream.

The controller decodes the selection word into a positive-input index and a negative-input index. There are eight channels, and index 8 stands for the shared common terminal. The controller presents an 8-bit trial code to the external ladder and comparator and reads back one compare bit. All serial timing is taken from edges of the serial clock. The block oversamples that clock with a faster system clock and passes it through a synchronizer. The serial output is given as a data bit plus a drive-enable, so the pad or the bench can release the line when the enable is low.

Top module: `sar_serial_ctl`

## Requirements
- R1: While `frame_n` is high, `ser_out_en` and `conv_busy` are 0 and `trial_code` is 0. After reset the block accepts no frame until `frame_n` has been high at least once, so a frame needs a high-to-low transition of `frame_n`.
- R2: `ser_in` is sampled on rising serial-clock edges. Zeros before the first 1 are ignored, and the first 1 is the start bit.
- R3: The four bits after the start bit, in order, are mode, odd, g1 and g0. When mode=1 (single-ended), `pos_sel` = odd + 2·g0 + 4·g1 and `neg_sel` = 8 (common terminal).
- R4: When mode=0 (differential), the pair is channels 2·{g1,g0} and 2·{g1,g0}+1. With odd=0 the even channel is `pos_sel` and the odd channel is `neg_sel`; with odd=1 the roles swap.
- R5: On the first falling serial-clock edge after the last address bit, `conv_busy` rises, and `ser_out_en` rises with `ser_out`=0 for that one settling period.
- R6: On each of the next 8 falling edges the compare bit is taken, MSB first, and driven on `ser_out`. `trial_code` changes only on falling edges or on a frame clear. With an ideal comparator (compare=1 when pos−neg ≥ trial) the result equals pos−neg.
- R7: When the positive input is below the negative input, every decision is 0 and the result is 00000000.
- R8: `conv_busy` falls on the first rising serial-clock edge after the eighth decision.
- R9: After the eighth decision `ser_out` shows bit 0. On a falling edge with `lsb_hold`=1 it stays unchanged; on a falling edge with `lsb_hold`=0 it steps to the next higher bit, covering bits 1 to 7 in turn, without repeating bit 0.
- R10: The falling edge with `lsb_hold`=0 that follows bit 7 drives `ser_out` to 0. `ser_out` stays 0, with `ser_out_en`=1, until `frame_n` goes high, and further start bits in that frame are ignored.
- R11: After the address is complete, `ser_in` has no effect on any output for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial start bit and address input |
| lsb_hold | input | 1 | High holds the current bit of the LSB-first stream |
| cmp_in | input | 1 | Comparator decision: positive minus negative is at least the trial code |
| ser_out | output | 1 | Serial result data |
| ser_out_en | output | 1 | Drive enable for ser_out (0 = released) |
| conv_busy | output | 1 | Conversion in progress |
| trial_code | output | RES_W | Trial code to the external ladder |
| pos_sel | output | 4 | Positive input index (0..7) |
| neg_sel | output | 4 | Negative input index (0..7, 8 = common) |

## Verification
The hardest case to reach is the LSB-first stream with the hold input switching on some falling edges and not on others. The stream must step exactly once for each released edge, must never replay bit 0, and must end in a steady low. The random frames choose a new hold pattern for every falling edge and toggle `ser_in` throughout the conversion and the replay. The bench then compares each serial bit with the result computed from the channel voltages it picked. Directed frames cover the full-scale code, a zero difference, a reversed pair, leading zeros, and a start bit sent after reset before `frame_n` has ever gone high.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

    localparam int NUM_CH    = 8;
    localparam int CH_W      = $clog2(NUM_CH + 1);
    localparam int ADDR_BITS = 4;
    localparam logic [CH_W-1:0] CH_COM = CH_W'(NUM_CH);

    typedef enum logic [2:0] {
        ST_LOCK,
        ST_HUNT,
        ST_ADDR,
        ST_ARMED,
        ST_SETTLE,
        ST_CONV,
        ST_TAIL,
        ST_DONE
    } frame_st_e;

    // Address word in arrival order: mode, odd, group[1], group[0]
    typedef struct packed {
        logic       single;
        logic       odd;
        logic [1:0] grp;
    } mux_word_t;

    typedef struct packed {
        logic [CH_W-1:0] pos;
        logic [CH_W-1:0] neg;
    } mux_sel_t;

    function automatic mux_sel_t decode_mux(input mux_word_t w);
        mux_sel_t s;
        // The positive index is {group, odd} in both modes.
        s.pos = CH_W'({w.grp, w.odd});
        if (w.single) begin
            s.neg = CH_COM;
        end else begin
            s.neg = CH_W'({w.grp, ~w.odd});
        end
        return s;
    endfunction

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise,
    output logic fall
);

    logic level;
    logic level_q;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign level = sig;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q <= '0;
                end else begin
                    sync_q[0] <= sig;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        sync_q[i] <= sync_q[i-1];
                    end
                end
            end
            assign level = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;

endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
    import sar_ctl_pkg::*;
#(
    parameter int RES_W = 8,
    localparam int IDX_W = $clog2(RES_W),
    localparam int CNT_W = (IDX_W > 2) ? IDX_W : 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             ser_in,
    input  logic             lsb_hold,
    output mux_word_t        addr_w,
    output logic             busy,
    output logic             drv_en,
    output logic             load_trial,
    output logic             decide,
    output logic [IDX_W-1:0] bit_idx,
    output logic             replay,
    output logic [IDX_W-1:0] rep_idx,
    output logic             force_zero
);

    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(RES_W - 1);
    localparam logic [CNT_W-1:0] CONV_TOP  = CNT_W'(RES_W - 2);

    frame_st_e              state;
    logic [CNT_W-1:0]       cnt;
    logic [ADDR_BITS-1:0]   addr_q;
    logic                   busy_q;
    logic                   drv_q;
    logic                   advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_LOCK;
            cnt    <= '0;
            addr_q <= '0;
            busy_q <= 1'b0;
            drv_q  <= 1'b0;
        end else if (frame_n) begin
            state  <= ST_HUNT;
            cnt    <= '0;
            addr_q <= '0;
            busy_q <= 1'b0;
            drv_q  <= 1'b0;
        end else begin
            case (state)
                ST_HUNT: begin
                    if (sclk_rise && ser_in) begin
                        state <= ST_ADDR;
                        cnt   <= '0;
                    end
                end
                ST_ADDR: begin
                    if (sclk_rise) begin
                        addr_q <= {addr_q[ADDR_BITS-2:0], ser_in};
                        if (cnt == ADDR_LAST) begin
                            state <= ST_ARMED;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_ARMED: begin
                    if (sclk_fall) begin
                        state  <= ST_SETTLE;
                        busy_q <= 1'b1;
                        drv_q  <= 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (sclk_fall) begin
                        state <= ST_CONV;
                        cnt   <= CONV_TOP;
                    end
                end
                ST_CONV: begin
                    if (sclk_fall) begin
                        if (cnt == '0) begin
                            state <= ST_TAIL;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (sclk_rise) begin
                        busy_q <= 1'b0;
                    end
                    if (advance) begin
                        if (cnt == BIT_LAST) begin
                            state <= ST_DONE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        advance    = (state == ST_TAIL) && sclk_fall && !lsb_hold;
        load_trial = (state == ST_ARMED) && sclk_fall;
        decide     = ((state == ST_SETTLE) || (state == ST_CONV)) && sclk_fall;
        bit_idx    = (state == ST_SETTLE) ? IDX_W'(RES_W - 1) : IDX_W'(cnt);
        replay     = advance && (cnt != BIT_LAST);
        force_zero = advance && (cnt == BIT_LAST);
        rep_idx    = IDX_W'(cnt + 1'b1);
    end

    assign addr_w = mux_word_t'(addr_q);
    assign busy   = busy_q;
    assign drv_en = drv_q;

endmodule

// File: rtl/sar_result_sreg.sv
module sar_result_sreg #(
    parameter int RES_W = 8,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load_trial,
    input  logic             decide,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp_in,
    input  logic             replay,
    input  logic [IDX_W-1:0] rep_idx,
    input  logic             force_zero,
    output logic [RES_W-1:0] trial,
    output logic             sdo
);

    localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] trial_q;
    logic [RES_W-1:0] trial_next;
    logic             sdo_q;

    // Settle the current bit and raise the next lower trial bit.
    always_comb begin
        trial_next          = trial_q;
        trial_next[bit_idx] = cmp_in;
        if (bit_idx != '0) begin
            trial_next[bit_idx - IDX_W'(1)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            trial_q <= '0;
            sdo_q   <= 1'b0;
        end else if (load_trial) begin
            trial_q <= MSB_ONE;
            sdo_q   <= 1'b0;
        end else if (decide) begin
            trial_q <= trial_next;
            sdo_q   <= cmp_in;
        end else if (replay) begin
            sdo_q   <= trial_q[rep_idx];
        end else if (force_zero) begin
            sdo_q   <= 1'b0;
        end
    end

    assign trial = trial_q;
    assign sdo   = sdo_q;

endmodule

// File: rtl/sar_serial_ctl.sv
module sar_serial_ctl
    import sar_ctl_pkg::*;
#(
    parameter int RES_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic             sclk,
    input  logic             ser_in,
    input  logic             lsb_hold,
    input  logic             cmp_in,
    output logic             ser_out,
    output logic             ser_out_en,
    output logic             conv_busy,
    output logic [RES_W-1:0] trial_code,
    output logic [CH_W-1:0]  pos_sel,
    output logic [CH_W-1:0]  neg_sel
);

    logic             sclk_rise;
    logic             sclk_fall;
    mux_word_t        addr_w;
    mux_sel_t         sel;
    logic             load_trial;
    logic             decide;
    logic [IDX_W-1:0] bit_idx;
    logic             replay;
    logic [IDX_W-1:0] rep_idx;
    logic             force_zero;

    sar_edge_det #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (sclk),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    sar_frame_seq #(
        .RES_W(RES_W)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .frame_n    (frame_n),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .ser_in     (ser_in),
        .lsb_hold   (lsb_hold),
        .addr_w     (addr_w),
        .busy       (conv_busy),
        .drv_en     (ser_out_en),
        .load_trial (load_trial),
        .decide     (decide),
        .bit_idx    (bit_idx),
        .replay     (replay),
        .rep_idx    (rep_idx),
        .force_zero (force_zero)
    );

    sar_result_sreg #(
        .RES_W(RES_W)
    ) i_res (
        .clk        (clk),
        .rst        (rst),
        .clear      (frame_n),
        .load_trial (load_trial),
        .decide     (decide),
        .bit_idx    (bit_idx),
        .cmp_in     (cmp_in),
        .replay     (replay),
        .rep_idx    (rep_idx),
        .force_zero (force_zero),
        .trial      (trial_code),
        .sdo        (ser_out)
    );

    assign sel     = decode_mux(addr_w);
    assign pos_sel = sel.pos;
    assign neg_sel = sel.neg;

endmodule

// File: rtl/sar_serial_ctl_chk.sv
module sar_serial_ctl_chk
    import sar_ctl_pkg::*;
#(
    parameter int RES_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_n,
    input logic             sclk_rise,
    input logic             sclk_fall,
    input logic             ser_out_en,
    input logic             conv_busy,
    input logic [RES_W-1:0] trial_code,
    input logic [CH_W-1:0]  pos_sel,
    input logic [CH_W-1:0]  neg_sel
);

    // R1: a high frame select releases the line and drops the status
    a_r1_frame_release: assert property (@(posedge clk) disable iff (rst)
        frame_n |=> (!ser_out_en && !conv_busy && trial_code == '0));

    // R4: a differential pair is always two adjacent channels of one group
    a_r4_pair_adjacent: assert property (@(posedge clk) disable iff (rst)
        (ser_out_en && neg_sel != CH_COM) |->
            (pos_sel[CH_W-1:1] == neg_sel[CH_W-1:1] && pos_sel[0] != neg_sel[0]));

    // R5: status rises only after a falling serial edge
    a_r5_busy_rise_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_busy) |-> $past(sclk_fall));

    // R5: while converting, the output line is driven
    a_r5_busy_drives_line: assert property (@(posedge clk) disable iff (rst)
        conv_busy |-> ser_out_en);

    // R6: the trial code moves only on falling edges or a frame clear
    a_r6_trial_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(trial_code) |-> ($past(sclk_fall) || $past(frame_n)));

    // R8: status drops on a rising serial edge unless a clear caused it
    a_r8_busy_fall_on_rise: assert property (@(posedge clk) disable iff (rst)
        ($fell(conv_busy) && !$past(frame_n)) |-> $past(sclk_rise));

endmodule

bind sar_serial_ctl sar_serial_ctl_chk #(
    .RES_W(RES_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (frame_n),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .ser_out_en (ser_out_en),
    .conv_busy  (conv_busy),
    .trial_code (trial_code),
    .pos_sel    (pos_sel),
    .neg_sel    (neg_sel)
);

// File: tb/test_sar_serial_ctl.sv
module test_sar_serial_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_n = 1'b0;
    logic       sclk = 1'b0;
    logic       ser_in = 1'b0;
    logic       lsb_hold = 1'b0;
    logic       cmp_in;
    logic       ser_out;
    logic       ser_out_en;
    logic       conv_busy;
    logic [7:0] trial_code;
    logic [3:0] pos_sel;
    logic [3:0] neg_sel;

    logic [7:0] ana [0:8];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic busy_hi;

    always #5 clk = ~clk;

    sar_serial_ctl i_sar_serial_ctl (
        .clk        (clk),
        .rst        (rst),
        .frame_n    (frame_n),
        .sclk       (sclk),
        .ser_in     (ser_in),
        .lsb_hold   (lsb_hold),
        .cmp_in     (cmp_in),
        .ser_out    (ser_out),
        .ser_out_en (ser_out_en),
        .conv_busy  (conv_busy),
        .trial_code (trial_code),
        .pos_sel    (pos_sel),
        .neg_sel    (neg_sel)
    );

    // Ideal differential comparator model
    always_comb begin
        cmp_in = 1'b0;
        if (pos_sel <= 4'd8 && neg_sel <= 4'd8) begin
            cmp_in = (int'(ana[pos_sel]) - int'(ana[neg_sel])) >= int'(trial_code);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pos(input logic [3:0] a);
        return int'(a[2]) + 2 * int'(a[0]) + 4 * int'(a[1]);
    endfunction

    function automatic int exp_neg(input logic [3:0] a);
        if (a[3]) return 8;
        return 2 * int'({a[1], a[0]}) + int'(!a[2]);
    endfunction

    task automatic pulse(input logic d);
        ser_in = d;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        busy_hi = conv_busy;
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_frame(input logic [3:0] a, input int nz, input bit noisy, input int hold_pct);
        int p;
        int n;
        int raw;
        int r;
        int idx;
        string rq;
        p = exp_pos(a);
        n = exp_neg(a);
        raw = int'(ana[p]) - int'(ana[n]);
        r = (raw > 0) ? raw : 0;
        rq = (raw < 0) ? "R7" : "R6";
        @(negedge clk);
        frame_n = 1'b0;
        lsb_hold = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nz; i++) pulse(1'b0);
        chk("R2 leading zeros leave line released", int'(ser_out_en), 0);
        pulse(1'b1);
        for (int i = 3; i >= 0; i--) pulse(a[i]);
        chk(a[3] ? "R3 pos_sel" : "R4 pos_sel", int'(pos_sel), p);
        chk(a[3] ? "R3 neg_sel" : "R4 neg_sel", int'(neg_sel), n);
        chk("R5 busy low before settle edge", int'(busy_hi), 0);
        chk("R5 busy after settle edge", int'(conv_busy), 1);
        chk("R5 line driven", int'(ser_out_en), 1);
        chk("R5 settle zero", int'(ser_out), 0);
        for (int k = 7; k >= 0; k--) begin
            pulse(noisy ? 1'($urandom % 2) : 1'b0);
            chk("R6 busy during conversion", int'(busy_hi), 1);
            chk(rq, int'(ser_out), (r >> k) & 1);
        end
        idx = 0;
        for (int g = 0; g < 40; g++) begin
            bit h;
            h = (($urandom % 100) < hold_pct);
            lsb_hold = h;
            pulse(noisy ? 1'($urandom % 2) : 1'b1);
            chk("R8 busy low after last decision", int'(busy_hi), 0);
            if (!h) idx++;
            if (idx >= 8) begin
                chk("R10 tail low", int'(ser_out), 0);
                break;
            end
            chk("R9 lsb-first stream (R11 noise)", int'(ser_out), (r >> idx) & 1);
        end
        lsb_hold = 1'b0;
        pulse(1'b1);
        pulse(1'b1);
        pulse(1'b0);
        chk("R10 stays low", int'(ser_out), 0);
        chk("R10 no new frame", int'(conv_busy), 0);
        chk("R10 still driven", int'(ser_out_en), 1);
        @(negedge clk);
        frame_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 released", int'(ser_out_en), 0);
        chk("R1 busy clear", int'(conv_busy), 0);
        chk("R1 trial clear", int'(trial_code), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234_5a5a));
        for (int i = 0; i <= 8; i++) ana[i] = 8'd0;
        repeat (4) @(negedge clk);
        chk("R1 reset line released", int'(ser_out_en), 0);
        chk("R1 reset busy", int'(conv_busy), 0);
        chk("R1 reset trial", int'(trial_code), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // Frame select has never been high: the start bit must be ignored
        pulse(1'b1);
        pulse(1'b1);
        pulse(1'b0);
        pulse(1'b1);
        pulse(1'b1);
        pulse(1'b0);
        chk("R1 no frame without falling select", int'(ser_out_en), 0);
        chk("R1 no busy without falling select", int'(conv_busy), 0);
        frame_n = 1'b1;
        repeat (3) @(negedge clk);

        // Directed: single-ended channel 3 against common
        ana[3] = 8'd200;
        run_frame(4'b1101, 3, 1'b0, 0);
        // Directed: full scale on pair 6/7
        ana[6] = 8'd255; ana[7] = 8'd0;
        run_frame(4'b0011, 0, 1'b0, 30);
        // Directed: reversed pair gives zero
        run_frame(4'b0111, 1, 1'b0, 0);
        // Directed: equal inputs give zero
        ana[0] = 8'd77; ana[1] = 8'd77;
        run_frame(4'b0000, 2, 1'b1, 50);
        // Directed: single-ended channel 0 with non-zero common
        ana[8] = 8'd100; ana[0] = 8'd99;
        run_frame(4'b1000, 0, 1'b1, 0);

        for (int f = 0; f < 40; f++) begin
            for (int i = 0; i <= 8; i++) ana[i] = 8'($urandom);
            if (f % 4 == 0) ana[8] = 8'd0;
            run_frame(4'($urandom), int'($urandom % 4), 1'b1, int'($urandom % 70));
        end
        finish_run();
    end

endmodule